// File: doc/BRIEF.md
# Three-Channel Short-Circuit and Over-Voltage Fault Sequencer

This block supervises the protection state of three independent converter channels. Each channel supplies a short-circuit flag, an over-voltage flag and a dimming input. For each channel the block returns two registered outputs. The first is a disable output that forces the switch gate and the load disconnect off. The second is a discharge output that grounds the channel's loop-compensation node. The block also reports a shared busy status. The comparators that raise the flags sit outside the block. The short-circuit comparator trips at twice the regulated current, and the block sees only its flag.

Short circuits recover on their own. A single counter in clock cycles stands in for a timing capacitor and sets the retry delay for all channels. Any valid short-circuit detection clears the counter. The counter ramps only once no channel is flagging a short. When it reaches full scale, every channel that is waiting on a short is released in the same cycle, and healthy channels are never touched.

A short-circuit flag is disregarded for a short window after its own channel's dimming input rises, so the inrush spike at turn-on is not mistaken for a fault. Over-voltage faults latch. They clear only when the enable input is taken low and brought high again. While enable is low, every channel is held off and all latched state is cleared.

Top module: `hiccup_fault_seq`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `ch_off` and `comp_dis` are all ones, `tmr_busy` is 0 and the retry counter is 0.
- R2: Bit i of every per-channel vector belongs to channel i. A valid short detection on channel i sets `ch_off[i]` and `comp_dis[i]` from the edge at which it is sampled. The bits of the other channels do not change.
- R3: Any valid short detection clears the retry counter to 0 at that edge. `tmr_busy` is 1 from that edge until the release edge.
- R4: The counter starts ramping at the first edge with no valid detection while a channel is pending and the counter is below LOW_NUM/LOW_DEN of full scale. A flag held for H edges therefore keeps its channel off for H-1+RAMP_CYCLES sampled cycles.
- R5: At the release edge every pending channel clears `ch_off` and `comp_dis` together, and `tmr_busy` falls at that same edge.
- R6: A valid detection on any channel while the counter is ramping restarts the ramp. Release then happens RAMP_CYCLES edges after that last detection, for all pending channels together.
- R7: A short flag is ignored at the edge that first samples its channel's `dim` bit high and at the BLANK_CYCLES edges that follow. It is acted on at the next edge.
- R8: An over-voltage flag sets `ch_off` of its channel and latches it, leaving `comp_dis` low. Retry releases do not clear this latch. Only a low level on `en` clears it.
- R9: An edge with `en` low forces `ch_off` and `comp_dis` to all ones, `tmr_busy` to 0 and the counter to 0, and clears every latch. At the first edge after `en` returns high, the outputs of fault-free channels are low.
- R10: A channel that shorts again after a retry is detected again and passes through a full new hiccup cycle of the same length, with no limit on the number of retries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| en | input | 1 | Enable; low holds everything off and clears latched faults |
| dim | input | NCH | Dimming input per channel, high = on; its rising edge starts blanking |
| sc_flag | input | NCH | Short-circuit comparator flag per channel |
| ov_flag | input | NCH | Over-voltage comparator flag per channel |
| ch_off | output | NCH | Gate and disconnect disable per channel |
| comp_dis | output | NCH | Compensation-node discharge per channel |
| tmr_busy | output | 1 | High while any channel waits for a retry |

## Verification
The bench builds the block with RAMP_CYCLES=16, BLANK_CYCLES=4 and the default one-fifth low mark. This keeps a full hiccup cycle short enough to sweep every channel against several flag hold lengths and to count each off period exactly. The small blanking window lets the bench probe the last ignored sample and the first honoured one on every channel. The short ramp also allows a second channel's fault to be injected mid-ramp, and it makes repeated retries and over-voltage latch persistence across several hiccup cycles cheap to run.

// File: rtl/hfs_pkg.sv
package hfs_pkg;
  // Low-threshold point of the retry counter as a fraction of full scale.
  function automatic int low_mark(input int full, input int num, input int den);
    return (full * num) / den;
  endfunction
endpackage

// File: rtl/hfs_blank.sv
module hfs_blank #(
  parameter int BLANK_CYCLES = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic dim,
  input  logic sc_flag,
  output logic det
);
  generate
    if (BLANK_CYCLES == 0) begin : g_noblank
      assign det = sc_flag;
    end else begin : g_blank
      localparam int BW = $clog2(BLANK_CYCLES + 1);
      logic          dim_q;
      logic [BW-1:0] bcnt;
      logic          rise;

      assign rise = dim & ~dim_q;
      assign det  = sc_flag & ~rise & (bcnt == '0);

      always_ff @(posedge clk) begin
        if (rst) begin
          dim_q <= 1'b0;
          bcnt  <= '0;
        end else begin
          dim_q <= dim;
          if (rise)
            bcnt <= BW'(BLANK_CYCLES);
          else if (bcnt != '0)
            bcnt <= bcnt - 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/hfs_timer.sv
module hfs_timer #(
  parameter int RAMP_CYCLES = 4000,
  parameter int LOW_NUM     = 1,
  parameter int LOW_DEN     = 5,
  parameter int CW          = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          det_any,
  input  logic          pend_any,
  output logic          rel,
  output logic          busy,
  output logic [CW-1:0] cnt
);
  import hfs_pkg::*;

  localparam logic [CW-1:0] FULL     = CW'(RAMP_CYCLES);
  localparam logic [CW-1:0] TOP      = CW'(RAMP_CYCLES - 1);
  localparam logic [CW-1:0] LOW_MARK = CW'(low_mark(RAMP_CYCLES, LOW_NUM, LOW_DEN));

  logic ramp;

  assign rel = ramp & (cnt == TOP) & ~det_any;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      ramp <= 1'b0;
      busy <= 1'b0;
    end else if (det_any) begin
      cnt  <= '0;
      ramp <= 1'b0;
      busy <= 1'b1;
    end else if (ramp) begin
      if (cnt == TOP) begin
        cnt  <= FULL;
        ramp <= 1'b0;
        busy <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (pend_any && (cnt < LOW_MARK)) begin
      ramp <= 1'b1;
      cnt  <= CW'(1);
    end
  end
endmodule

// File: rtl/hfs_chan.sv
module hfs_chan (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic det,
  input  logic ov_flag,
  input  logic rel,
  output logic sc_pend,
  output logic ch_off,
  output logic comp_dis
);
  logic ov_lat;
  logic sc_nxt;
  logic ov_nxt;
  logic hold;

  assign hold = rst | ~en;

  always_comb begin
    if (hold) begin
      sc_nxt = 1'b0;
      ov_nxt = 1'b0;
    end else begin
      sc_nxt = det ? 1'b1 : (rel ? 1'b0 : sc_pend);
      ov_nxt = ov_lat | ov_flag;
    end
  end

  always_ff @(posedge clk) begin
    sc_pend  <= sc_nxt;
    ov_lat   <= ov_nxt;
    ch_off   <= hold | sc_nxt | ov_nxt;
    comp_dis <= hold | sc_nxt;
  end
endmodule

// File: rtl/hiccup_fault_seq.sv
module hiccup_fault_seq #(
  parameter int NCH          = 3,
  parameter int RAMP_CYCLES  = 4000,
  parameter int LOW_NUM      = 1,
  parameter int LOW_DEN      = 5,
  parameter int BLANK_CYCLES = 50
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [NCH-1:0] dim,
  input  logic [NCH-1:0] sc_flag,
  input  logic [NCH-1:0] ov_flag,
  output logic [NCH-1:0] ch_off,
  output logic [NCH-1:0] comp_dis,
  output logic           tmr_busy
);
  localparam int CW = $clog2(RAMP_CYCLES + 1);

  logic [NCH-1:0] sc_det;
  logic [NCH-1:0] sc_pend;
  logic           tmr_rel;
  logic [CW-1:0]  tmr_cnt;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    hfs_blank #(.BLANK_CYCLES(BLANK_CYCLES)) u_blank (
      .clk     (clk),
      .rst     (rst),
      .dim     (dim[i]),
      .sc_flag (sc_flag[i]),
      .det     (sc_det[i])
    );

    hfs_chan u_chan (
      .clk      (clk),
      .rst      (rst),
      .en       (en),
      .det      (sc_det[i]),
      .ov_flag  (ov_flag[i]),
      .rel      (tmr_rel),
      .sc_pend  (sc_pend[i]),
      .ch_off   (ch_off[i]),
      .comp_dis (comp_dis[i])
    );
  end

  hfs_timer #(
    .RAMP_CYCLES (RAMP_CYCLES),
    .LOW_NUM     (LOW_NUM),
    .LOW_DEN     (LOW_DEN),
    .CW          (CW)
  ) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .det_any  (|sc_det),
    .pend_any (|sc_pend),
    .rel      (tmr_rel),
    .busy     (tmr_busy),
    .cnt      (tmr_cnt)
  );
endmodule

// File: rtl/hfs_checker.sv
module hfs_checker #(
  parameter int NCH         = 3,
  parameter int CW          = 12,
  parameter int RAMP_CYCLES = 4000
) (
  input logic           clk,
  input logic           rst,
  input logic           en,
  input logic [NCH-1:0] sc_det,
  input logic [NCH-1:0] ch_off,
  input logic [NCH-1:0] comp_dis,
  input logic           tmr_busy,
  input logic [CW-1:0]  tmr_cnt
);
  p_por_state_r1: assert property (@(posedge clk)
    rst |=> (&ch_off && &comp_dis && !tmr_busy && tmr_cnt == '0));

  p_discharge_needs_off_r2: assert property (@(posedge clk) disable iff (rst)
    ((comp_dis & ~ch_off) == '0));

  p_det_clears_timer_r3: assert property (@(posedge clk) disable iff (rst)
    (en && |sc_det) |=> (tmr_cnt == '0 && tmr_busy));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    (tmr_cnt <= CW'(RAMP_CYCLES)));

  p_joint_release_r5: assert property (@(posedge clk) disable iff (rst)
    ($fell(tmr_busy) && $past(en) && !$past(rst)) |-> (comp_dis == '0));

  p_enable_low_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (&ch_off && &comp_dis && !tmr_busy));
endmodule

bind hiccup_fault_seq hfs_checker #(
  .NCH         (NCH),
  .CW          (CW),
  .RAMP_CYCLES (RAMP_CYCLES)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .sc_det   (sc_det),
  .ch_off   (ch_off),
  .comp_dis (comp_dis),
  .tmr_busy (tmr_busy),
  .tmr_cnt  (tmr_cnt)
);

// File: tb/hiccup_fault_seq_bench.sv
module hiccup_fault_seq_bench;
  localparam int NCH   = 3;
  localparam int RAMP  = 16;
  localparam int BLANK = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           en  = 1'b1;
  logic [NCH-1:0] dim = '0;
  logic [NCH-1:0] sc_flag = '0;
  logic [NCH-1:0] ov_flag = '0;
  logic [NCH-1:0] ch_off;
  logic [NCH-1:0] comp_dis;
  logic           tmr_busy;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  hiccup_fault_seq #(
    .NCH(NCH), .RAMP_CYCLES(RAMP), .LOW_NUM(1), .LOW_DEN(5), .BLANK_CYCLES(BLANK)
  ) u_hiccup_fault_seq (
    .clk(clk), .rst(rst), .en(en), .dim(dim), .sc_flag(sc_flag), .ov_flag(ov_flag),
    .ch_off(ch_off), .comp_dis(comp_dis), .tmr_busy(tmr_busy)
  );

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // Ticks until channel c output clears, counting the clearing tick.
  task automatic wait_release(input int c, output int m);
    m = 0;
    do begin
      tick();
      m++;
    end while (ch_off[c] && m < 1000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int m;
    int n;
    // R1: reset state
    tick(); tick();
    chk("R1 ch_off", ch_off, 7);
    chk("R1 comp_dis", comp_dis, 7);
    chk("R1 busy", tmr_busy, 0);
    rst = 1'b0;
    dim = '1;
    repeat (BLANK + 3) tick();
    chk("R9 idle outputs", ch_off, 0);

    // R2 R3 R4 R5: each channel, several flag hold lengths
    for (int c = 0; c < NCH; c++) begin
      for (int h = 1; h <= 3; h++) begin
        sc_flag[c] = 1'b1;
        tick();
        chk("R2 ch_off one channel", ch_off, 1 << c);
        chk("R2 comp_dis one channel", comp_dis, 1 << c);
        chk("R3 busy set", tmr_busy, 1);
        n = 1;
        for (int k = 1; k < h; k++) begin
          tick();
          if (ch_off[c]) n++;
        end
        sc_flag[c] = 1'b0;
        wait_release(c, m);
        chk("R4 off duration", n + m - 1, h + RAMP - 1);
        chk("R5 all released", ch_off, 0);
        chk("R5 comp released", comp_dis, 0);
        chk("R5 busy fell", tmr_busy, 0);
      end
    end

    // R6: second channel faults mid-ramp; joint release
    sc_flag[0] = 1'b1; tick(); sc_flag[0] = 1'b0;
    repeat (6) tick();
    sc_flag[1] = 1'b1; tick(); sc_flag[1] = 1'b0;
    chk("R6 both off", ch_off, 3);
    m = 0;
    n = 0;
    do begin
      tick();
      m++;
      if (ch_off != 3 && ch_off != 0) n++;
    end while (ch_off != 0 && m < 1000);
    chk("R6 restart length", m, RAMP);
    chk("R6 no partial release", n, 0);

    // R7: blanking after a dim rising edge
    for (int c = 0; c < NCH; c++) begin
      dim[c] = 1'b0;
      tick(); tick();
      dim[c] = 1'b1;
      sc_flag[c] = 1'b1;
      n = 0;
      for (int k = 0; k <= BLANK; k++) begin
        tick();
        if (ch_off != 0) n++;
      end
      chk("R7 ignored in window", n, 0);
      tick();
      chk("R7 honoured after window", ch_off, 1 << c);
      sc_flag[c] = 1'b0;
      wait_release(c, m);
      chk("R7 release length", m, RAMP);
    end

    // R8 R9: over-voltage latch, cleared only by enable cycle
    for (int c = 0; c < NCH; c++) begin
      ov_flag[c] = 1'b1; tick(); ov_flag[c] = 1'b0;
      chk("R8 ov off", ch_off, 1 << c);
      chk("R8 ov comp", comp_dis, 0);
      chk("R8 ov busy", tmr_busy, 0);
      sc_flag[(c + 1) % NCH] = 1'b1; tick(); sc_flag[(c + 1) % NCH] = 1'b0;
      wait_release((c + 1) % NCH, m);
      repeat (RAMP) tick();
      chk("R8 latch survives release", ch_off, 1 << c);
      en = 1'b0; tick();
      chk("R9 en low off", ch_off, 7);
      chk("R9 en low comp", comp_dis, 7);
      en = 1'b1; tick();
      chk("R8 cleared by enable cycle", ch_off, 0);
    end

    // R9: enable low during a hiccup cancels it
    sc_flag[2] = 1'b1; tick(); sc_flag[2] = 1'b0;
    repeat (3) tick();
    en = 1'b0; tick();
    chk("R9 busy cleared", tmr_busy, 0);
    en = 1'b1; tick();
    chk("R9 resume", ch_off, 0);
    chk("R9 resume comp", comp_dis, 0);

    // R10: repeated shorts retry without limit
    for (int r = 0; r < 4; r++) begin
      sc_flag[1] = 1'b1; tick(); sc_flag[1] = 1'b0;
      chk("R10 re-detected", ch_off, 2);
      wait_release(1, m);
      chk("R10 cycle length", m, RAMP);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule